// File: doc/BRIEF.md
# Serial Flash Single-Lane Transaction Sequencer

This block runs one serial-flash transaction on a one-bit SPI bus under software control. Software fills a small set of word registers with the command bytes, the 24-bit address, an option data byte, the dummy length, the write word and a phase-enable word. It then writes the control word with the start bit set and polls the status word until the transfer-end flag comes up. A transaction is built from up to six phases, each switched on or off on its own. Phases that are on always go out in one fixed order.

The bus runs in SPI mode 0, most significant bit first. SCK toggles on every system clock, so it runs at half the system clock rate. Read data is collected into a read-data register, left-aligned. A keep-select control leaves chip select low when a transfer ends. Several 32-bit transfers can then form one flash operation: a command and address in one transfer, followed by several data words.

Top module: `spi_flash_seq`

## Requirements
- R1: Enabled phases are sent back to back in this order: command, option command, address, option data, dummy, data. Disabled phases contribute no SCK edges, so the total bit count is the sum of the enabled phase lengths.
- R2: Command phase: phase-enable bit 14 sends the command byte held in register 1 bits 23:16. Option-command phase: phase-enable bit 12 sends the byte in register 1 bits 7:0. Each byte is 8 bits, MSB first.
- R3: Address phase: phase-enable bits 11:8 equal to 4'h7 send the 24-bit address from register 2 bits 23:0, MSB first. Any other value sends no address.
- R4: Option-data phase: phase-enable bits 7:4 nonzero send the byte in register 3 bits 7:0. Zero skips the phase.
- R5: Dummy phase: phase-enable bit 15 sends (register 5 bits 3:0) + 1 clocks with MOSI low.
- R6: Data phase: phase-enable bits 3:0 select the length: 4'hF gives 32 bits, 4'hC gives 16 bits, 4'h8 gives 8 bits, and any other value skips the phase. When control bit 1 is set, the data sent is the top bits of register 6, MSB first. When control bit 1 is clear, MOSI is low.
- R7: When control bit 2 is set and a data phase ran, register 7 holds the sampled MISO bits left-aligned, the first bit in bit 31 and the lower bits zero. Otherwise register 7 keeps its previous value.
- R8: SPI mode 0. SCK is low while chip select is high. Each SCK high lasts one system clock. MOSI is stable across the rising edge, and MISO is sampled at the end of the SCK high time.
- R9: Status (a read of register 0) bit 0 is set when the last enabled phase finishes. It is cleared by an accepted start.
- R10: A write to register 0 while a transfer runs is ignored entirely: no restart, and no change to the control bits.
- R11: With control bit 8 set, chip select stays low after the transfer ends and status bit 1 reads 1. The next transfer continues the same select period. A transfer ending with bit 8 clear releases chip select, and status bit 1 reads 0.
- R12: After reset, chip select is high, SCK is low, the status reads 0 and register 7 reads 0.
- R13: The register index map is: 0 control (bit 0 start, bit 1 transmit, bit 2 receive, bit 8 keep select) on write and status on read, 1 command bytes, 2 address, 3 option data, 4 phase enable, 5 dummy length, 6 write word, 7 read word. Read data appears one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Register read data, one clock after reg_rd |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench sweeps 256 phase-enable combinations. These cover every on/off mix of command, option command, option data and dummy. They include the address selector at its sending value and at non-sending values, every data-length code plus an undefined one, and transmit/receive both on, both off or split. The recorded MOSI stream is cut into per-phase segments, which separates a wrong byte source from a wrong order or a wrong skip. Every transfer carries a different pseudo-random MISO pattern, so a misaligned or mis-edged read capture shows in the read word. Separate runs cover a chained keep-select pair that must form one continuous stream, a mid-transfer control write that must neither restart nor retarget the transfer, and register readback.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] RIX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] RIX_CMD  = 3'd1;
  localparam logic [IDX_W-1:0] RIX_ADDR = 3'd2;
  localparam logic [IDX_W-1:0] RIX_OPD  = 3'd3;
  localparam logic [IDX_W-1:0] RIX_PHEN = 3'd4;
  localparam logic [IDX_W-1:0] RIX_DMY  = 3'd5;
  localparam logic [IDX_W-1:0] RIX_WDAT = 3'd6;
  localparam logic [IDX_W-1:0] RIX_RDAT = 3'd7;

  typedef enum logic [2:0] {
    PH_CMD  = 3'd0,
    PH_OCMD = 3'd1,
    PH_ADDR = 3'd2,
    PH_OPD  = 3'd3,
    PH_DMY  = 3'd4,
    PH_DATA = 3'd5,
    PH_END  = 3'd6
  } phase_e;

  typedef struct packed {
    logic       dmy_en;
    logic       cmd_en;
    logic       ocmd_en;
    logic [3:0] addr_sel;
    logic [3:0] opd_sel;
    logic [3:0] data_sel;
  } phen_t;

  typedef struct packed {
    logic keep;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/spiseq_regs.sv
module spiseq_regs
  import spiseq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  input  logic             busy_i,
  input  logic             end_i,
  input  logic             sel_i,
  input  logic             rx_load_i,
  input  logic [W-1:0]     rx_word_i,
  output logic             start_o,
  output ctrl_t            ctrl_o,
  output logic [7:0]       cmd_o,
  output logic [7:0]       ocmd_o,
  output logic [23:0]      addr_o,
  output logic [7:0]       opd_o,
  output phen_t            phen_o,
  output logic [3:0]       dmy_o,
  output logic [W-1:0]     wdat_o
);
  logic [15:0]  en_q;
  logic [W-1:0] rdat_q;

  assign start_o = wr_i && (idx_i == RIX_CTRL) && wdata_i[0];

  assign phen_o = '{dmy_en:   en_q[15],
                    cmd_en:   en_q[14],
                    ocmd_en:  en_q[12],
                    addr_sel: en_q[11:8],
                    opd_sel:  en_q[7:4],
                    data_sel: en_q[3:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      cmd_o  <= '0;
      ocmd_o <= '0;
      addr_o <= '0;
      opd_o  <= '0;
      en_q   <= '0;
      dmy_o  <= '0;
      wdat_o <= '0;
      rdat_q <= '0;
    end else begin
      if (wr_i) begin
        unique case (idx_i)
          RIX_CTRL: if (!busy_i) ctrl_o <= '{keep: wdata_i[8], rx_en: wdata_i[2], tx_en: wdata_i[1]};
          RIX_CMD:  begin cmd_o <= wdata_i[23:16]; ocmd_o <= wdata_i[7:0]; end
          RIX_ADDR: addr_o <= wdata_i[23:0];
          RIX_OPD:  opd_o  <= wdata_i[7:0];
          RIX_PHEN: en_q   <= wdata_i[15:0];
          RIX_DMY:  dmy_o  <= wdata_i[3:0];
          RIX_WDAT: wdat_o <= wdata_i;
          default:  ;
        endcase
      end
      if (rx_load_i) rdat_q <= rx_word_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      unique case (idx_i)
        RIX_CTRL: rdata_o <= {{(W-2){1'b0}}, sel_i, end_i};
        RIX_CMD:  rdata_o <= {{(W-24){1'b0}}, cmd_o, 8'h00, ocmd_o};
        RIX_ADDR: rdata_o <= {{(W-24){1'b0}}, addr_o};
        RIX_OPD:  rdata_o <= {{(W-8){1'b0}}, opd_o};
        RIX_PHEN: rdata_o <= {{(W-16){1'b0}}, en_q};
        RIX_DMY:  rdata_o <= {{(W-4){1'b0}}, dmy_o};
        RIX_WDAT: rdata_o <= wdat_o;
        default:  rdata_o <= rdat_q;
      endcase
    end
  end
endmodule

// File: rtl/spiseq_shift.sv
module spiseq_shift #(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [W-1:0]     word_i,
  input  logic [CNT_W-1:0] bits_i,
  input  logic             miso_i,
  output logic             done_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic [W-1:0]     rx_o
);
  logic             active_q;
  logic             half_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      cnt_q    <= '0;
      tx_q     <= '0;
      rx_o     <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i && !active_q) begin
        active_q <= 1'b1;
        half_q   <= 1'b0;
        cnt_q    <= bits_i;
        tx_q     <= word_i;
        rx_o     <= '0;
      end else if (active_q) begin
        if (!half_q) begin
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          rx_o   <= {rx_o[W-2:0], miso_i};
          tx_q   <= {tx_q[W-2:0], 1'b0};
          cnt_q  <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = half_q;
  assign mosi_o = tx_q[W-1];

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (bits_i != '0)); // R5
  AST_MOSI_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> $stable(mosi_o)); // R8
  AST_SCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sck_o |=> !sck_o); // R8
endmodule

// File: rtl/spiseq_ctl.sv
module spiseq_ctl
  import spiseq_pkg::*;
#(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  ctrl_t            ctrl_i,
  input  logic [7:0]       cmd_i,
  input  logic [7:0]       ocmd_i,
  input  logic [23:0]      addr_i,
  input  logic [7:0]       opd_i,
  input  phen_t            phen_i,
  input  logic [3:0]       dmy_i,
  input  logic [W-1:0]     wdat_i,
  input  logic             sh_done_i,
  input  logic [W-1:0]     sh_rx_i,
  output logic             busy_o,
  output logic             end_o,
  output logic             cs_n_o,
  output logic             sh_load_o,
  output logic [W-1:0]     sh_word_o,
  output logic [CNT_W-1:0] sh_bits_o,
  output logic             rx_load_o,
  output logic [W-1:0]     rx_word_o
);
  phase_e           ph_q;
  logic             wait_q;
  logic             ph_on;
  logic [W-1:0]     ph_word;
  logic [CNT_W-1:0] ph_bits;
  logic [CNT_W-1:0] dbits;

  always_comb begin
    unique case (phen_i.data_sel)
      4'hF:    dbits = CNT_W'(W);
      4'hC:    dbits = CNT_W'(W / 2);
      4'h8:    dbits = CNT_W'(W / 4);
      default: dbits = '0;
    endcase
  end

  always_comb begin
    ph_on   = 1'b0;
    ph_word = '0;
    ph_bits = '0;
    unique case (ph_q)
      PH_CMD:  begin ph_on = phen_i.cmd_en;  ph_word = {cmd_i, {(W-8){1'b0}}};  ph_bits = CNT_W'(8); end
      PH_OCMD: begin ph_on = phen_i.ocmd_en; ph_word = {ocmd_i, {(W-8){1'b0}}}; ph_bits = CNT_W'(8); end
      PH_ADDR: begin ph_on = (phen_i.addr_sel == 4'h7); ph_word = {addr_i, {(W-24){1'b0}}}; ph_bits = CNT_W'(24); end
      PH_OPD:  begin ph_on = (phen_i.opd_sel != 4'h0); ph_word = {opd_i, {(W-8){1'b0}}}; ph_bits = CNT_W'(8); end
      PH_DMY:  begin ph_on = phen_i.dmy_en; ph_bits = CNT_W'(dmy_i) + CNT_W'(1); end
      PH_DATA: begin ph_on = (dbits != '0); ph_word = ctrl_i.tx_en ? wdat_i : '0; ph_bits = dbits; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      end_o     <= 1'b0;
      cs_n_o    <= 1'b1;
      ph_q      <= PH_CMD;
      wait_q    <= 1'b0;
      sh_load_o <= 1'b0;
      sh_word_o <= '0;
      sh_bits_o <= '0;
      rx_load_o <= 1'b0;
      rx_word_o <= '0;
    end else begin
      sh_load_o <= 1'b0;
      rx_load_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          end_o  <= 1'b0;
          cs_n_o <= 1'b0;
          ph_q   <= PH_CMD;
          wait_q <= 1'b0;
        end
      end else if (wait_q) begin
        if (sh_done_i) begin
          wait_q <= 1'b0;
          ph_q   <= phase_e'(ph_q + 3'd1);
          if (ph_q == PH_DATA && ctrl_i.rx_en) begin
            rx_load_o <= 1'b1;
            rx_word_o <= sh_rx_i << (W - int'(dbits));
          end
        end
      end else if (ph_q == PH_END) begin
        busy_o <= 1'b0;
        end_o  <= 1'b1;
        if (!ctrl_i.keep) cs_n_o <= 1'b1;
      end else if (ph_on) begin
        sh_load_o <= 1'b1;
        sh_word_o <= ph_word;
        sh_bits_o <= ph_bits;
        wait_q    <= 1'b1;
      end else begin
        ph_q <= phase_e'(ph_q + 3'd1);
      end
    end
  end

  AST_PHASE_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> (ph_q >= $past(ph_q))); // R1
  AST_START_CLEARS_END: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && !end_o)); // R9
  AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && ph_q != PH_END) |=> (busy_o && ph_q >= $past(ph_q))); // R10
  AST_KEEP_HOLDS_SEL: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && ctrl_i.keep) |-> !cs_n_o); // R11
  AST_NOKEEP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !ctrl_i.keep) |-> cs_n_o); // R11
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spiseq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              start, busy, xend, sh_load, sh_done, rx_load;
  ctrl_t             ctrl;
  phen_t             phen;
  logic [7:0]        cmd, ocmd, opd;
  logic [23:0]       addr;
  logic [3:0]        dmy;
  logic [WORD_W-1:0] wdat, sh_word, sh_rx, rx_word;
  logic [CNT_W-1:0]  sh_bits;

  spiseq_regs #(.W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .rd_i(reg_rd), .idx_i(reg_idx),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy), .end_i(xend),
    .sel_i(!spi_cs_n), .rx_load_i(rx_load), .rx_word_i(rx_word),
    .start_o(start), .ctrl_o(ctrl), .cmd_o(cmd), .ocmd_o(ocmd), .addr_o(addr),
    .opd_o(opd), .phen_o(phen), .dmy_o(dmy), .wdat_o(wdat)
  );

  spiseq_ctl #(.W(WORD_W)) u_ctl (
    .clk(clk), .rst(rst), .start_i(start), .ctrl_i(ctrl), .cmd_i(cmd),
    .ocmd_i(ocmd), .addr_i(addr), .opd_i(opd), .phen_i(phen), .dmy_i(dmy),
    .wdat_i(wdat), .sh_done_i(sh_done), .sh_rx_i(sh_rx), .busy_o(busy),
    .end_o(xend), .cs_n_o(spi_cs_n), .sh_load_o(sh_load), .sh_word_o(sh_word),
    .sh_bits_o(sh_bits), .rx_load_o(rx_load), .rx_word_o(rx_word)
  );

  spiseq_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(sh_load), .word_i(sh_word), .bits_i(sh_bits),
    .miso_i(spi_miso), .done_o(sh_done), .sck_o(spi_sck), .mosi_o(spi_mosi),
    .rx_o(sh_rx)
  );

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck); // R8
endmodule

// File: tb/test_spi_flash_seq.sv
module test_spi_flash_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  int vec_n = 0, bad_n = 0, cyc = 0;
  logic [255:0] rec = '0;
  int rec_n = 0, midx = 0, r8_bad = 0;
  logic prev_sck = 1'b0;
  logic [31:0] exp_rdat = '0;

  always #2.5 clk = ~clk;

  spi_flash_seq i_spi_flash_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic pbit(int i);
    logic [31:0] h;
    h = (i * 32'h9E3779B1) ^ 32'h5A5A1234;
    return h[19] ^ h[7];
  endfunction

  // flash-side model: records MOSI at SCK rise, moves MISO after SCK fall
  always @(negedge clk) begin
    if (!spi_cs_n) begin
      if (spi_sck && !prev_sck) begin
        if (rec_n < 256) rec[rec_n] = spi_mosi;
        rec_n++;
      end
      if (!spi_sck && prev_sck) midx++;
    end
    if (spi_sck && prev_sck) r8_bad++;
    if (spi_cs_n && spi_sck) r8_bad++;
    prev_sck = spi_sck;
    spi_miso = pbit(midx);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad_n++;
      $display("FAIL watchdog: got %0d cycles exp < 190000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vec_n++;
    if (got !== exp) begin
      bad_n++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk); reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk); reg_rd = 1'b1; reg_idx = idx;
    @(negedge clk); reg_rd = 1'b0; val = reg_rdata;
  endtask

  task automatic seg(input string tag, input int at, input int n, input logic [31:0] v);
    logic [31:0] got, exp;
    got = '0; exp = '0;
    for (int j = 0; j < n; j++) begin
      got[31-j] = (at + j < 256) ? rec[at+j] : 1'bx;
      exp[31-j] = v[31-j];
    end
    chk(tag, got, exp);
  endtask

  function automatic int dlen(input logic [3:0] sel);
    case (sel)
      4'hF: return 32;
      4'hC: return 16;
      4'h8: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic run(input logic [15:0] en, input logic [7:0] cmd, input logic [7:0] ocmd,
                     input logic [23:0] addr, input logic [7:0] opd, input logic [3:0] dmy,
                     input logic [31:0] wdat, input logic tx, input logic rx, input logic keep,
                     input logic fresh, input logic dbl);
    logic [31:0] st, rv, ex;
    int base, pos, n, guard;
    if (fresh) begin rec_n = 0; midx = 0; end
    base = rec_n;
    wr(3'd1, {8'h00, cmd, 8'h00, ocmd});
    wr(3'd2, {8'h00, addr});
    wr(3'd3, {24'h0, opd});
    wr(3'd4, {16'h0, en});
    wr(3'd5, {28'h0, dmy});
    wr(3'd6, wdat);
    wr(3'd0, {23'h0, keep, 5'h0, rx, tx, 1'b1});
    rd(3'd0, st);
    chk("R9 end flag clear after start", {31'h0, st[0]}, 32'h0);
    if (dbl) wr(3'd0, {23'h0, ~keep, 5'h0, ~rx, ~tx, 1'b1}); // R10 ignored write
    guard = 0;
    do begin rd(3'd0, st); guard++; end while (!st[0] && guard < 1000);
    chk("R9 end flag set", {31'h0, st[0]}, 32'h1);
    pos = base;
    if (en[14]) begin seg("R2 command byte", pos, 8, {cmd, 24'h0}); pos += 8; end
    if (en[12]) begin seg("R2 option command byte", pos, 8, {ocmd, 24'h0}); pos += 8; end
    if (en[11:8] == 4'h7) begin seg("R3 address", pos, 24, {addr, 8'h0}); pos += 24; end
    if (en[7:4] != 4'h0) begin seg("R4 option data", pos, 8, {opd, 24'h0}); pos += 8; end
    if (en[15]) begin
      n = int'(dmy) + 1;
      seg("R5 dummy low", pos, (n > 32) ? 32 : n, 32'h0);
      pos += n;
    end
    n = dlen(en[3:0]);
    if (n > 0) begin
      seg("R6 data out", pos, n, tx ? wdat : 32'h0);
      if (rx) begin
        ex = '0;
        for (int j = 0; j < n; j++) ex[31-j] = pbit(pos + j);
        exp_rdat = ex;
      end
      pos += n;
    end
    chk("R1 total bit count", rec_n - base, pos - base);
    chk("R11 select status", {31'h0, st[1]}, {31'h0, keep});
    chk("R11 chip select pin", {31'h0, spi_cs_n}, {31'h0, ~keep});
    rd(3'd7, rv);
    chk("R7 read word", rv, exp_rdat);
  endtask

  initial begin
    logic [31:0] v, lcg;
    lcg = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 cs high after reset", {31'h0, spi_cs_n}, 32'h1);
    chk("R12 sck low after reset", {31'h0, spi_sck}, 32'h0);
    rd(3'd0, v); chk("R12 status zero", v, 32'h0);
    rd(3'd7, v); chk("R12 read word zero", v, 32'h0);

    wr(3'd1, 32'h00A5_003C);
    rd(3'd1, v); chk("R13 command readback", v, 32'h00A5_003C);
    wr(3'd2, 32'hFF12_3456);
    rd(3'd2, v); chk("R13 address readback", v, 32'h0012_3456);
    wr(3'd6, 32'hCAFE_F00D);
    rd(3'd6, v); chk("R13 write word readback", v, 32'hCAFE_F00D);

    // sweep of phase combinations
    for (int idx = 0; idx < 256; idx++) begin
      logic [15:0] en;
      logic [3:0]  dsel, asel;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      asel = idx[2] ? 4'h7 : {2'b00, idx[4], idx[3]};
      case (idx[6:5])
        2'd0: dsel = idx[0] ? 4'h5 : 4'h0;
        2'd1: dsel = 4'h8;
        2'd2: dsel = 4'hC;
        default: dsel = 4'hF;
      endcase
      en = {idx[4], idx[0], 1'b0, idx[1], asel, idx[3] ? 4'h4 : 4'h0, dsel};
      run(en, lcg[31:24] ^ 8'h5A, lcg[15:8], lcg[27:4], lcg[7:0] ^ 8'hC3,
          4'(idx * 5), lcg ^ 32'h8E1F_02D7, idx[7], idx[7] ^ idx[2], 1'b0, 1'b1, 1'b0);
    end

    // R11 chained pair under one select period
    run(16'h4000, 8'h0B, 8'h00, 24'h0, 8'h00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run(16'h000F, 8'h00, 8'h00, 24'h0, 8'h00, 4'h0, 32'h9ABC_DEF0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 chained stream length", rec_n, 40);

    // R10 control write mid-transfer ignored
    run(16'hC70F, 8'h3B, 8'h00, 24'hABCDEF, 8'h00, 4'h7, 32'h1357_9BDF,
        1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R10 no restart stream length", rec_n, 8 + 24 + 8 + 32);

    chk("R8 sck timing violations", r8_bad, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule